// File: doc/BRIEF.md
# Replicated Periodic Load Pulse Generator

This block issues the parallel-load command that every channel of a multi-channel serial waveform generator uses to take its next data word. Once in every frame of `RING_LEN` system clock cycles it raises a load vector for exactly one cycle. The vector holds several identical copies of the pulse, and each copy is meant to drive a separate group of channel shift registers. Because no single flop then drives all the channels, the fanout on each net stays small at very high clock rates.

No counter or comparator sets the timing. Two identical one-hot ring shift registers produce it. A single set bit circulates through each ring. One fixed ring position is the tap, and the tap is registered into the load copies, which adds one cycle of latency. The lower copies come from ring A and the upper copies come from ring B. An optional frame-start flag marks the cycle that follows each load. A mismatch output compares the two rings on every cycle. If a ring ever leaves the one-hot state, it restarts from its clear value.

Top module: `load_pulse_gen`

## Requirements
- R1: While rst_ni is low, load_o, frame_o and mismatch_o are all zero, and they become zero at once when reset is asserted.
- R2: Each load pulse lasts exactly one cycle. Within one reset period, consecutive pulses are exactly RING_LEN (default 10) cycles apart.
- R3: Count n as the number of rising clock edges since rst_ni was released. load_o is high exactly when n >= 1 and (n-1) mod RING_LEN equals TAP_IDX (default 8), so the first pulse follows edge 9. load_o is zero after the first edge.
- R4: All LOAD_W (default 5) bits of load_o are equal on every cycle: either 5'h1F or 5'h00.
- R5: With EN_FRAME=1, frame_o is high exactly on the cycle after each load pulse, that is, when n >= 1 and (n-1) mod RING_LEN equals (TAP_IDX+1) mod RING_LEN.
- R6: Each ring holds one set bit, starting at bit 0 after reset and moving up one position per edge, with wrap-around. A ring state that is zero or has several bits set is replaced by 0x001 on the next edge, so the pulse cadence continues without end.
- R7: mismatch_o is high exactly when the two rings differ. With both rings healthy it stays low.
- R8: Asserting reset in the middle of a frame restarts the phase, so the next pulse timing follows R3 again from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous clear |
| load_o | output | LOAD_W | Replicated registered load pulse |
| frame_o | output | 1 | Registered flag on the first cycle of a new frame |
| mismatch_o | output | 1 | High when the two rings disagree |

## Verification
The bench applies reset at random points and holds it for random lengths, so a frame is cut at every phase. A design that kept its ring phase across reset, or that let a stale tap reach the output on the first edge, would then pulse at the wrong cycle. Each load pulse is timed against the one before it: an off-by-one ring length or a wrong tap shows up as a bad gap or a misplaced first pulse. If one ring were wired with a different tap or shift direction, the load bits would split and mismatch_o would rise. A long uninterrupted run confirms that the cadence neither drifts nor dies.

// File: rtl/load_pulse_pkg.sv
package load_pulse_pkg;
  function automatic logic is_onehot(input logic [63:0] v);
    return (v != '0) && ((v & (v - 64'd1)) == '0);
  endfunction
endpackage

// File: rtl/onehot_ring.sv
module onehot_ring import load_pulse_pkg::*; #(
  parameter int unsigned LEN = 10,
  parameter int unsigned TAP = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [LEN-1:0] ring_o,
  output logic           tap_o
);
  localparam logic [LEN-1:0] SEED = LEN'(1);

  logic [LEN-1:0] q;
  logic           healthy;

  assign healthy = is_onehot(64'(q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= SEED;
    else if (!healthy) q <= SEED;  // self-repair
    else               q <= {q[LEN-2:0], q[LEN-1]};
  end

  assign ring_o = q;
  assign tap_o  = q[TAP];

  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(q));
  a_r6_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(q) |=> q == {$past(q[LEN-2:0]), $past(q[LEN-1])});
  a_r6_repair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$onehot(q) |=> q == SEED);
endmodule

// File: rtl/load_fanout.sv
module load_fanout #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned A_BITS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tap_a_i,
  input  logic             tap_b_i,
  output logic [WIDTH-1:0] load_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic src;
    if (i < A_BITS) begin : g_a
      assign src = tap_a_i;
    end else begin : g_b
      assign src = tap_b_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) load_o[i] <= 1'b0;
      else         load_o[i] <= en_i & src;
    end
  end
endmodule

// File: rtl/load_pulse_gen.sv
module load_pulse_gen #(
  parameter int unsigned RING_LEN = 10,
  parameter int unsigned TAP_IDX  = 8,
  parameter int unsigned LOAD_W   = 5,
  parameter int unsigned A_BITS   = 3,
  parameter bit          EN_FRAME = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LOAD_W-1:0] load_o,
  output logic              frame_o,
  output logic              mismatch_o
);
  localparam int unsigned FRAME_IDX = (TAP_IDX + 1) % RING_LEN;

  logic [RING_LEN-1:0] ring_a, ring_b;
  logic                tap_a, tap_b;
  logic                primed_q;

  onehot_ring #(.LEN(RING_LEN), .TAP(TAP_IDX)) u_ring_a (
    .clk_i, .rst_ni, .ring_o(ring_a), .tap_o(tap_a));
  onehot_ring #(.LEN(RING_LEN), .TAP(TAP_IDX)) u_ring_b (
    .clk_i, .rst_ni, .ring_o(ring_b), .tap_o(tap_b));

  // blanks the output on the first edge after clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  load_fanout #(.WIDTH(LOAD_W), .A_BITS(A_BITS)) u_fanout (
    .clk_i, .rst_ni, .en_i(primed_q), .tap_a_i(tap_a), .tap_b_i(tap_b),
    .load_o);

  if (EN_FRAME) begin : g_frame
    logic frame_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) frame_q <= 1'b0;
      else         frame_q <= primed_q & ring_a[FRAME_IDX];
    end
    assign frame_o = frame_q;

    a_r5_frame_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|load_o) |=> frame_o);
  end else begin : g_noframe
    assign frame_o = 1'b0;
  end

  assign mismatch_o = (ring_a != ring_b);

  a_r4_bits_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o == '0) || (&load_o));
  a_r2_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|load_o) |=> (load_o == '0));
  a_r7_rings_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mismatch_o);
  a_r1_first_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |=> (load_o == '0));
endmodule

// File: tb/load_pulse_gen_bench.sv
module load_pulse_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RING_LEN   = 10;
  localparam int TAP_IDX    = 8;
  localparam int LOAD_W     = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LOAD_W-1:0] load;
  logic              frame, mismatch;

  int total = 0, bad = 0;
  int n = 0;
  int last_pulse = -1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_pulse_gen u_load_pulse_gen (
    .clk_i(clk), .rst_ni(rst_n), .load_o(load), .frame_o(frame),
    .mismatch_o(mismatch));

  always @(posedge clk) n <= rst_n ? n + 1 : 0;

  function automatic logic exp_load(int k);
    return (k >= 1) && (((k - 1) % RING_LEN) == TAP_IDX);
  endfunction
  function automatic logic exp_frame(int k);
    return (k >= 1) && (((k - 1) % RING_LEN) == ((TAP_IDX + 1) % RING_LEN));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h n=%0d", req, act, exp, n);
    end
  endtask

  task automatic check_cycle(string tag);
    logic [LOAD_W-1:0] e;
    e = exp_load(n) ? '1 : '0;
    check(load == e, {tag, " R3 load phase"}, load, e);
    check((load == '0) || (&load), "R4 bits equal", load, '1);
    check(frame == exp_frame(n), "R5 frame", frame, exp_frame(n));
    check(!mismatch, "R7 mismatch", mismatch, 0);
    if (|load) begin
      if (last_pulse >= 0)
        check(n - last_pulse == RING_LEN, "R2 pulse spacing", n - last_pulse, RING_LEN);
      last_pulse = n;
    end
  endtask

  task automatic do_reset(int cycles);
    rst_n = 1'b0;
    #1;
    check(load == '0 && !frame && !mismatch, "R1 reset outputs", {frame, load}, 0);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(load == '0 && !frame && !mismatch, "R1 held reset", {frame, load}, 0);
    end
    last_pulse = -1;
    rst_n = 1'b1;
  endtask

  task automatic run(int cycles, string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_cycle(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset(2);
    run(1, "R3 first edge");
    check(load == '0, "R3 blank after release", load, 0);
    run(34, "R3 initial");
    // reset at every phase of the frame
    for (int ph = 0; ph < RING_LEN; ph++) begin
      run(ph, "R8 pre");
      do_reset(1);
      run(25, "R8 restart");
    end
    // random reset points and lengths
    for (int k = 0; k < 40; k++) begin
      do_reset(1 + ($urandom % 3));
      run(3 + ($urandom % 60), "R8 random");
    end
    // long run: cadence persists with one-hot rings
    do_reset(1);
    run(1000, "R6 long run");
    check(last_pulse == 1000 - ((1000 - 1 - TAP_IDX) % RING_LEN),
          "R6 cadence alive", last_pulse, 1000 - ((1000 - 1 - TAP_IDX) % RING_LEN));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule